// File: doc/BRIEF.md
# Bayer 3x3 Colour Interpolator

The block turns a raster of raw 8-bit samples taken through a Bayer colour filter (one colour per site) into full RGB pixels. For each pixel, the two missing colours are estimated from the 3x3 neighbourhood around it. Two line memories hold the two previous raw lines. A 3x3 register window slides along the current line and is fed by the new sample and the two memory taps.

The raw window is two samples wider and two lines taller than the image that comes out: by default 642x482 samples in and 640x480 pixels out. The outermost ring of samples serves only as neighbourhood context and is never emitted. The input is a sample stream with a valid qualifier and a start-of-frame marker. The output is an RGB stream with the same kind of qualifiers, delayed by one line plus a fixed number of clocks.

Top module: `bayer3x3_demosaic`

## Requirements
- R1: The output component that matches the colour of the centre site equals the centre raw sample unchanged.
- R2: At a green site on a red-bearing row, red is the mean of the left and right samples and blue is the mean of the samples above and below. At a green site on a blue-bearing row, these two roles are swapped.
- R3: At a red or blue site, green is the mean of the four orthogonal neighbours, and the opposite colour is the mean of the four diagonal neighbours.
- R4: Every mean is truncated (the sum shifted right by 1 or 2), so each component stays 8 bits wide.
- R5: Parameter PHASE sets the site colour as code = {y[0]^PHASE[1], x[0]^PHASE[0]}, where x and y are raw coordinates. Code 0 is red, 1 is green on a red row, 2 is green on a blue row and 3 is blue. PHASE 0 gives an RGGB pattern and 3 gives BGGR.
- R6: Each frame yields exactly (W-2)x(H-2) output pixels, in raster order. Output (i,j) is centred on raw sample (i+1,j+1). The first and last raw rows and columns produce no output.
- R7: out_sof is high together with the first output pixel of a frame and at no other time.
- R8: The output pixel centred on raw (i,j) is presented exactly two clocks after raw sample (i+1,j+1) is accepted.
- R9: When in_vld is low, no state advances. Samples that arrive after reset and before the first in_sof, or after a frame's last sample and before the next in_sof, produce no output.
- R10: During and just after reset, out_vld, out_sof and all colour outputs are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_vld | input | 1 | Raw sample valid |
| in_sof | input | 1 | Marks the sample at raw (0,0); qualified by in_vld |
| in_data | input | DW | Raw Bayer sample |
| out_vld | output | 1 | RGB pixel valid |
| out_sof | output | 1 | First pixel of an output frame |
| out_red | output | DW | Red component |
| out_grn | output | DW | Green component |
| out_blu | output | DW | Blue component |

## Verification
The hardest case to reach from the ports is a stream with gaps, where the window and the line memories must stand still across idle cycles without losing their alignment with the Bayer phase. One frame in the stimulus table drops in_vld on every other cycle, and its expected pixels are the same as for a gap-free frame. The unarmed state before and after a frame is reached by streaming a whole frame with no in_sof and requiring that nothing comes out. A second instance with PHASE 3 runs on the same stream, so that each site class is checked under both pattern alignments.

// File: rtl/bayer3x3_demosaic.sv
module bayer3x3_demosaic #(
  parameter int W     = 642,
  parameter int H     = 482,
  parameter int DW    = 8,
  parameter int PHASE = 0
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_vld,
  input  logic          in_sof,
  input  logic [DW-1:0] in_data,
  output logic          out_vld,
  output logic          out_sof,
  output logic [DW-1:0] out_red,
  output logic [DW-1:0] out_grn,
  output logic [DW-1:0] out_blu
);
  localparam int XW = $clog2(W);
  localparam int YW = $clog2(H + 1);
  localparam int OUT_PIX = (W - 2) * (H - 2);
  localparam logic [1:0] PH = PHASE[1:0];

  logic [XW-1:0] x_q;
  logic [YW-1:0] y_q;
  logic [DW-1:0] lb_a [W];
  logic [DW-1:0] lb_b [W];
  logic [DW-1:0] win [3][3];
  logic          s1_vld, s1_sof;
  logic [1:0]    s1_site;

  wire           live  = in_vld && (in_sof || y_q < YW'(H));
  wire [XW-1:0]  cx    = in_sof ? '0 : x_q;
  wire [YW-1:0]  cy    = in_sof ? '0 : y_q;
  wire [DW-1:0]  tap_a = lb_a[cx];
  wire [DW-1:0]  tap_b = lb_b[cx];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      x_q     <= '0;
      y_q     <= YW'(H);
      s1_vld  <= 1'b0;
      s1_sof  <= 1'b0;
      s1_site <= 2'd0;
    end else begin
      s1_vld <= 1'b0;
      s1_sof <= 1'b0;
      if (live) begin
        if (cx == XW'(W - 1)) begin
          x_q <= '0;
          y_q <= cy + 1'b1;
        end else begin
          x_q <= cx + 1'b1;
          y_q <= cy;
        end
        s1_vld  <= (cx >= XW'(2)) && (cy >= YW'(2));
        s1_sof  <= (cx == XW'(2)) && (cy == YW'(2));
        s1_site <= {~cy[0] ^ PH[1], ~cx[0] ^ PH[0]};
      end
    end
  end

  always_ff @(posedge clk) begin
    if (live) begin
      lb_a[cx] <= in_data;
      lb_b[cx] <= tap_a;
      for (int r = 0; r < 3; r++) begin
        win[r][2] <= win[r][1];
        win[r][1] <= win[r][0];
      end
      win[0][0] <= tap_b;
      win[1][0] <= tap_a;
      win[2][0] <= in_data;
    end
  end

  wire [DW-1:0] ctr  = win[1][1];
  wire [DW:0]   hsum = {1'b0, win[1][0]} + {1'b0, win[1][2]};
  wire [DW:0]   vsum = {1'b0, win[0][1]} + {1'b0, win[2][1]};
  wire [DW+1:0] osum = {1'b0, hsum} + {1'b0, vsum};
  wire [DW+1:0] dsum = {2'b0, win[0][0]} + {2'b0, win[0][2]}
                     + {2'b0, win[2][0]} + {2'b0, win[2][2]};

  logic [DW-1:0] r_n, g_n, b_n;
  always_comb begin
    unique case (s1_site)
      2'd0:    begin r_n = ctr;             g_n = osum[DW+1:2]; b_n = dsum[DW+1:2]; end
      2'd1:    begin r_n = hsum[DW:1];      g_n = ctr;          b_n = vsum[DW:1];   end
      2'd2:    begin r_n = vsum[DW:1];      g_n = ctr;          b_n = hsum[DW:1];   end
      default: begin r_n = dsum[DW+1:2];    g_n = osum[DW+1:2]; b_n = ctr;          end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_vld <= 1'b0;
      out_sof <= 1'b0;
      out_red <= '0;
      out_grn <= '0;
      out_blu <= '0;
    end else begin
      out_vld <= s1_vld;
      out_sof <= s1_sof;
      if (s1_vld) begin
        out_red <= r_n;
        out_grn <= g_n;
        out_blu <= b_n;
      end
    end
  end

  int ocnt;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       ocnt <= 0;
    else if (out_sof) ocnt <= 1;
    else if (out_vld) ocnt <= ocnt + 1;
  end

  p_sof_qual_r7: assert property (@(posedge clk) disable iff (!rst_n)
    out_sof |-> out_vld);
  p_sof_single_r7: assert property (@(posedge clk) disable iff (!rst_n)
    out_sof |=> !out_sof);
  p_latency_r8: assert property (@(posedge clk) disable iff (!rst_n)
    out_vld |-> $past(in_vld, 2));
  p_frame_count_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (out_vld && !out_sof) |-> (ocnt < OUT_PIX));
endmodule

// File: tb/test_bayer3x3_demosaic.sv
module test_bayer3x3_demosaic;
  localparam int W = 8, H = 6, OW = W - 2, OH = H - 2;

  logic clk = 1'b0, rst_n = 1'b0;
  logic in_vld = 1'b0, in_sof = 1'b0;
  logic [7:0] in_data = '0;
  logic a_vld, a_sof, b_vld, b_sof;
  logic [7:0] a_r, a_g, a_b, b_r, b_g, b_b;

  always #2.5 clk = ~clk;

  bayer3x3_demosaic #(.W(W), .H(H), .DW(8), .PHASE(0)) i_bayer3x3_demosaic (
    .clk(clk), .rst_n(rst_n), .in_vld(in_vld), .in_sof(in_sof), .in_data(in_data),
    .out_vld(a_vld), .out_sof(a_sof), .out_red(a_r), .out_grn(a_g), .out_blu(a_b));
  bayer3x3_demosaic #(.W(W), .H(H), .DW(8), .PHASE(3)) i_bayer3x3_demosaic_b (
    .clk(clk), .rst_n(rst_n), .in_vld(in_vld), .in_sof(in_sof), .in_data(in_data),
    .out_vld(b_vld), .out_sof(b_sof), .out_red(b_r), .out_grn(b_g), .out_blu(b_b));

  // per frame: x gain, y gain, xy gain, offset, checker xor, gaps
  localparam int NPAT = 4;
  localparam int PAT [NPAT][6] = '{
    '{  7, 13,  3,  1, 0, 0},
    '{  0,  0,  0,  0, 1, 0},
    '{ 31, 17,  5, 200, 1, 1},
    '{ 1,   1, 11, 250, 0, 0}
  };

  int checks = 0, errors = 0, cyc = 0, t_mark = 0, kcur = 0, oca = 0, ocb = 0;

  always @(posedge clk) cyc <= cyc + 1;

  function automatic logic [7:0] pv(int k, int x, int y);
    logic [7:0] v;
    v = 8'((PAT[k][0] * x + PAT[k][1] * y + PAT[k][2] * x * y + PAT[k][3]) & 255);
    if (PAT[k][4] != 0 && ((x + y) % 2) == 1) v = ~v;
    return v;
  endfunction

  function automatic logic [23:0] expect_px(int ph, int k, int x, int y);
    int c, h, v, o, d, site;
    c = pv(k, x, y);
    h = pv(k, x - 1, y) + pv(k, x + 1, y);
    v = pv(k, x, y - 1) + pv(k, x, y + 1);
    o = (h + v) / 4;
    d = (pv(k, x - 1, y - 1) + pv(k, x + 1, y - 1) + pv(k, x - 1, y + 1) + pv(k, x + 1, y + 1)) / 4;
    site = (((y % 2) ^ ((ph >> 1) & 1)) << 1) | ((x % 2) ^ (ph & 1));
    case (site)
      0: return {8'(c), 8'(o), 8'(d)};
      1: return {8'(h / 2), 8'(c), 8'(v / 2)};
      2: return {8'(v / 2), 8'(c), 8'(h / 2)};
      default: return {8'(d), 8'(o), 8'(c)};
    endcase
  endfunction

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic watch(input int ph, input int oc, input logic sof,
                       input logic [7:0] r, input logic [7:0] g, input logic [7:0] b);
    logic [23:0] e;
    e = expect_px(ph, kcur, oc % OW + 1, oc / OW + 1);
    check({r, g, b} == e, "R1/R2/R3/R4/R5 pixel", {8'd0, r, g, b}, {8'd0, e});
    check(sof == (oc == 0), "R7 sof placement", 32'(sof), 32'(oc == 0));
    if (sof) check(cyc - t_mark == 2, "R8 latency", 32'(cyc - t_mark), 32'd2);
  endtask

  always @(negedge clk) begin
    if (rst_n && a_vld) begin watch(0, oca, a_sof, a_r, a_g, a_b); oca++; end
    if (rst_n && b_vld) begin watch(3, ocb, b_sof, b_r, b_g, b_b); ocb++; end
  end

  task automatic send_frame(input int k, input bit gaps, input bit with_sof);
    for (int y = 0; y < H; y++)
      for (int x = 0; x < W; x++) begin
        @(posedge clk); #1;
        in_vld  = 1'b1;
        in_sof  = with_sof && x == 0 && y == 0;
        in_data = pv(k, x, y);
        if (x == 2 && y == 2) t_mark = cyc;
        if (gaps) begin
          @(posedge clk); #1;
          in_vld  = 1'b0;
          in_sof  = 1'b0;
          in_data = ~in_data;
        end
      end
    @(posedge clk); #1;
    in_vld = 1'b0;
    in_sof = 1'b0;
    repeat (5) @(posedge clk);
  endtask

  initial begin
    #200000;
    errors++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    check({a_vld, a_sof, a_r, a_g, a_b} == '0, "R10 reset outputs", {6'd0, a_vld, a_sof, a_r, a_g, a_b}, 32'd0);
    rst_n = 1'b1;
    @(negedge clk);
    check({b_vld, b_sof, b_r, b_g, b_b} == '0, "R10 after reset", {6'd0, b_vld, b_sof, b_r, b_g, b_b}, 32'd0);

    // R9: stream without a start marker is ignored
    oca = 0; ocb = 0;
    send_frame(0, 1'b0, 1'b0);
    check(oca == 0 && ocb == 0, "R9 unarmed before sof", 32'(oca + ocb), 32'd0);

    for (int k = 0; k < NPAT; k++) begin
      kcur = k; oca = 0; ocb = 0;
      send_frame(k, PAT[k][5] != 0, 1'b1);
      check(oca == OW * OH, "R6 frame count A", 32'(oca), 32'(OW * OH));
      check(ocb == OW * OH, "R6 frame count B", 32'(ocb), 32'(OW * OH));
    end

    // R9: after a complete frame, extra samples without sof give nothing
    oca = 0; ocb = 0;
    send_frame(1, 1'b0, 1'b0);
    check(oca == 0 && ocb == 0, "R9 unarmed after frame", 32'(oca + ocb), 32'd0);

    // R6/R9: back-to-back frame after idle still aligned
    kcur = 2; oca = 0; ocb = 0;
    send_frame(2, 1'b0, 1'b1);
    check(oca == OW * OH, "R6 repeat frame", 32'(oca), 32'(OW * OH));

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule